// File: doc/BRIEF.md
# Eight-Lane Framed Serial Sample Transmitter

This block turns one parallel sample per channel into a one-bit serial lane per channel. It runs from a single fast clock at twelve times the sample rate, so each fast-clock cycle is one bit slot. Every twelve slots make a frame. In each frame every lane sends one 12-bit word. Two companion outputs are generated from the same slot counter as the data. The frame clock runs at the sample rate. The bit clock runs at half the slot rate, so a receiver captures one bit on each of its edges.

Samples enter through a valid/ready stream. The block raises ready for exactly one cycle per frame, in the last slot, whatever the state of valid. A sample is taken only when valid and ready are high together, and valid may be held or dropped freely. Holding valid low is the only form of back-pressure from the source, and the block never waits: a frame with no accepted sample sends an all-zero word on the sample path. Several controls are latched at that same frame boundary, so they never change a word half-way through: the source select (sample data, deskew, sync or a user word), the bit order, a per-lane power-down mask, and three 4-bit user-pattern nibbles.

Top module: `oser_octal_lane_serializer`

## Requirements
- R1: Slots count 0 to 11 and repeat. `frame_clk_o` is high in slots 0–5 and low in slots 6–11, so its rising edge marks slot 0, the first bit of a word. `s_ready_o` is high only in slot 11.
- R2: `bit_clk_o` is high in even slots and low in odd slots, so it changes level every fast-clock cycle.
- R3: With source code 0 (sample) and LSB-first order (`msb_first_i`=0), lane c sends bit t of its channel's sample in slot t. The sample is `s_data_i[c*12 +: 12]`.
- R4: With `msb_first_i`=1, slot t carries bit 11−t of the selected 12-bit word, for every source.
- R5: Source code 1 (deskew) sends 1,0,1,0,… starting with 1 in LSB-first order, and 0,1,0,1,… in MSB-first order.
- R6: Source code 2 (sync) sends six zeros then six ones in LSB-first order, and six ones then six zeros in MSB-first order.
- R7: Source code 3 (user word) sends `pat0_i` bits 0–3, then `pat1_i` bits 0–3, then `pat2_i` bits 0–3 in LSB-first order, and the reverse of that sequence in MSB-first order.
- R8: A sample is captured only at the rising edge that ends a slot-11 cycle in which `s_valid_i` is high. If no sample is captured there, the next frame sends zero on the sample path.
- R9: Changes to the source, bit order, power-down mask or pattern nibbles during slots 0–10 do not alter the word being sent. They apply from the next slot 0.
- R10: A lane whose `pd_mask_i` bit was set at the frame boundary drives 0 for the whole frame. Other lanes and both clocks are unaffected.
- R11: While `rst_n` is low, the counter holds slot 0, all lanes are 0, `frame_clk_o` is 1 and `s_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one bit slot per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid_i | input | 1 | Sample stream valid |
| s_ready_o | output | 1 | Sample stream ready, high in slot 11 |
| s_data_i | input | 96 | Eight packed 12-bit samples, channel c at bits c*12+11:c*12 |
| src_i | input | 2 | Word source: 0 sample, 1 deskew, 2 sync, 3 user word |
| msb_first_i | input | 1 | 1 selects MSB-first order |
| pd_mask_i | input | 8 | Per-lane power-down, bit c for lane c |
| pat0_i | input | 4 | User word, first nibble sent in LSB-first order |
| pat1_i | input | 4 | User word, second nibble |
| pat2_i | input | 4 | User word, third nibble |
| lane_o | output | 8 | Serial data lanes |
| frame_clk_o | output | 1 | Frame clock at the sample rate |
| bit_clk_o | output | 1 | Half-rate bit clock, both edges valid |

## Verification
Two things can happen in the same cycle. The block takes in a new sample and control set at the frame boundary, and it also sends bit 11 of the outgoing word and raises the frame clock for the incoming word. The bench drives new data, source, order and mask in the slot-11 cycle of every frame, and it checks that slot 11 still carries the old word while slot 0 carries the new one. In some frames the bench also changes all controls in the middle of the frame. Those frames must come out exactly as the values latched at the boundary predict.

// File: rtl/oser_pkg.sv
package oser_pkg;
  typedef enum logic [1:0] {
    SRC_SAMPLE = 2'd0,
    SRC_DESKEW = 2'd1,
    SRC_SYNC   = 2'd2,
    SRC_CUSTOM = 2'd3
  } src_e;
endpackage

// File: rtl/oser_slot_timer.sv
module oser_slot_timer #(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [$clog2(W)-1:0] slot_o,
  output logic                 last_o,
  output logic                 frame_o,
  output logic                 bitclk_o
);
  localparam int SW = $clog2(W);
  localparam logic [SW-1:0] LAST = SW'(W - 1);
  localparam logic [SW-1:0] HALF = SW'(W / 2);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              slot_q <= '0;
    else if (slot_q == LAST) slot_q <= '0;
    else                     slot_q <= slot_q + 1'b1;
  end

  assign slot_o   = slot_q;
  assign last_o   = (slot_q == LAST);
  assign frame_o  = (slot_q < HALF);
  assign bitclk_o = ~slot_q[0];

  // R1: the boundary slot is always followed by slot 0
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (slot_o == '0));
endmodule

// File: rtl/oser_word_sel.sv
module oser_word_sel
  import oser_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  src_e                 src,
  input  logic                 msb,
  input  logic                 pd,
  input  logic [W-1:0]         sample,
  input  logic [W-1:0]         custom,
  input  logic [$clog2(W)-1:0] slot,
  output logic                 bit_o
);
  localparam int SW = $clog2(W);
  localparam logic [SW-1:0] LAST = SW'(W - 1);
  localparam logic [SW-1:0] HALF = SW'(W / 2);

  logic [W-1:0]  deskew_w, sync_w, word;
  logic [SW-1:0] idx;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      deskew_w[i] = (i % 2 == 0);
      sync_w[i]   = (i >= W / 2);
    end
    unique case (src)
      SRC_SAMPLE: word = sample;
      SRC_DESKEW: word = deskew_w;
      SRC_SYNC:   word = sync_w;
      default:    word = custom;
    endcase
    idx   = msb ? (LAST - slot) : slot;
    bit_o = !pd && word[idx];
  end

  // R5: deskew alternates and starts with 1 in LSB order, 0 in MSB order
  a_r5_deskew_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_DESKEW && !pd) |-> (bit_o == (msb ? slot[0] : !slot[0])));
  // R6: first half of a sync word is zero in LSB order
  a_r6_sync_head: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_SYNC && !msb && slot < HALF) |-> !bit_o);
endmodule

// File: rtl/oser_octal_lane_serializer.sv
module oser_octal_lane_serializer
  import oser_pkg::*;
#(
  parameter int CH = 8,
  parameter int W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s_valid_i,
  output logic            s_ready_o,
  input  logic [CH*W-1:0] s_data_i,
  input  logic [1:0]      src_i,
  input  logic            msb_first_i,
  input  logic [CH-1:0]   pd_mask_i,
  input  logic [W/3-1:0]  pat0_i,
  input  logic [W/3-1:0]  pat1_i,
  input  logic [W/3-1:0]  pat2_i,
  output logic [CH-1:0]   lane_o,
  output logic            frame_clk_o,
  output logic            bit_clk_o
);
  localparam int SW = $clog2(W);

  logic [SW-1:0]   slot;
  logic            last;
  logic [CH*W-1:0] hold_q;
  src_e            src_q;
  logic            msb_q;
  logic [CH-1:0]   pd_q;
  logic [W-1:0]    cust_q;

  oser_slot_timer #(.W(W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_o   (slot),
    .last_o   (last),
    .frame_o  (frame_clk_o),
    .bitclk_o (bit_clk_o)
  );

  assign s_ready_o = last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      src_q  <= SRC_SAMPLE;
      msb_q  <= 1'b0;
      pd_q   <= '0;
      cust_q <= '0;
    end else if (last) begin
      hold_q <= s_valid_i ? s_data_i : '0;
      src_q  <= src_e'(src_i);
      msb_q  <= msb_first_i;
      pd_q   <= pd_mask_i;
      cust_q <= {pat2_i, pat1_i, pat0_i};
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_lane
    oser_word_sel #(.W(W)) u_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_q),
      .msb    (msb_q),
      .pd     (pd_q[c]),
      .sample (hold_q[c*W +: W]),
      .custom (cust_q),
      .slot   (slot),
      .bit_o  (lane_o[c])
    );
  end

  // R1: ready in the last slot is followed by the frame clock rising
  a_r1_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |=> $rose(frame_clk_o));
  // R2: bit clock changes level every cycle
  a_r2_bitclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bit_clk_o != $past(bit_clk_o)));
  // R8: held samples change only after a boundary cycle
  a_r8_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready_o |=> $stable(hold_q));
  // R9: latched controls change only after a boundary cycle
  a_r9_cfg_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready_o |=> $stable({src_q, msb_q, pd_q, cust_q}));
endmodule

// File: tb/test_oser_octal_lane_serializer.sv
module test_oser_octal_lane_serializer;
  localparam int CH = 8;
  localparam int W  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            s_valid_i = 1'b0;
  logic            s_ready_o;
  logic [CH*W-1:0] s_data_i = '0;
  logic [1:0]      src_i = 2'd0;
  logic            msb_first_i = 1'b0;
  logic [CH-1:0]   pd_mask_i = '0;
  logic [3:0]      pat0_i = '0, pat1_i = '0, pat2_i = '0;
  logic [CH-1:0]   lane_o;
  logic            frame_clk_o, bit_clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  oser_octal_lane_serializer #(.CH(CH), .W(W)) i_oser_octal_lane_serializer (
    .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .s_data_i(s_data_i), .src_i(src_i), .msb_first_i(msb_first_i),
    .pd_mask_i(pd_mask_i), .pat0_i(pat0_i), .pat1_i(pat1_i), .pat2_i(pat2_i),
    .lane_o(lane_o), .frame_clk_o(frame_clk_o), .bit_clk_o(bit_clk_o)
  );

  function automatic logic exp_bit(input logic [1:0] m, input logic msb,
                                   input logic [11:0] smp, input logic [11:0] cust,
                                   input int t);
    int k;
    logic [11:0] w;
    k = msb ? (11 - t) : t;
    case (m)
      2'd0:    w = smp;
      2'd1:    w = 12'h555;
      2'd2:    w = 12'hFC0;
      default: w = cust;
    endcase
    return w[k];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at a falling edge in slot 11; leaves at the falling edge of the next slot 11.
  task automatic do_frame(input logic [1:0] m, input logic msb, input logic [7:0] pd,
                          input logic v, input logic [95:0] d, input logic [11:0] cust,
                          input logic disturb);
    logic [95:0] eff;
    logic [7:0] ev;
    chk("R1 ready at boundary", 32'(s_ready_o), 32'd1);
    s_valid_i = v; s_data_i = d; src_i = m; msb_first_i = msb; pd_mask_i = pd;
    {pat2_i, pat1_i, pat0_i} = cust;
    eff = v ? d : '0;
    for (int t = 0; t < 12; t++) begin
      @(negedge clk);
      if (t == 0) begin
        s_valid_i = $urandom; s_data_i = {$urandom, $urandom, $urandom};
      end
      for (int c = 0; c < 8; c++)
        ev[c] = pd[c] ? 1'b0 : exp_bit(m, msb, eff[c*12 +: 12], cust, t);
      if (m == 2'd0 && !msb) chk("R3 sample lsb-first lanes", 32'(lane_o), 32'(ev));
      else if (m == 2'd0) chk("R4 sample msb-first lanes", 32'(lane_o), 32'(ev));
      else if (m == 2'd1) chk("R5 deskew lanes", 32'(lane_o), 32'(ev));
      else if (m == 2'd2) chk("R6 sync lanes", 32'(lane_o), 32'(ev));
      else chk("R7 user word lanes", 32'(lane_o), 32'(ev));
      if (pd != 0) chk("R10 powered-down lanes zero", 32'(lane_o & pd), 32'd0);
      chk("R1 frame clock", 32'(frame_clk_o), 32'(t < 6));
      chk("R2 bit clock", 32'(bit_clk_o), 32'(t % 2 == 0));
      if (t != 11) chk("R1 ready low mid-frame", 32'(s_ready_o), 32'd0);
      if (disturb && t == 5) begin
        // R9: controls change mid-frame; expectations keep the latched values
        src_i = m + 2'd1; msb_first_i = !msb; pd_mask_i = ~pd;
        {pat2_i, pat1_i, pat0_i} = ~cust;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 lanes in reset", 32'(lane_o), 32'd0);
    chk("R11 frame clock in reset", 32'(frame_clk_o), 32'd1);
    chk("R11 ready in reset", 32'(s_ready_o), 32'd0);
    rst_n = 1'b1;
    while (!s_ready_o) @(negedge clk);
    // R8: the first frame after reset had no sample; next frames are directed
    do_frame(2'd0, 1'b0, 8'h00, 1'b1, 96'h123456789ABCDEF012345678, 12'h000, 1'b0);
    do_frame(2'd0, 1'b1, 8'h00, 1'b1, 96'hFEDCBA9876543210A5A5C3C3, 12'h000, 1'b0);
    do_frame(2'd0, 1'b0, 8'h00, 1'b0, 96'hFFFFFFFFFFFFFFFFFFFFFFFF, 12'h000, 1'b0); // R8 no valid
    do_frame(2'd1, 1'b0, 8'h00, 1'b1, '0, 12'h000, 1'b0);
    do_frame(2'd1, 1'b1, 8'h00, 1'b1, '0, 12'h000, 1'b0);
    do_frame(2'd2, 1'b0, 8'h00, 1'b1, '0, 12'h000, 1'b0);
    do_frame(2'd2, 1'b1, 8'h00, 1'b1, '0, 12'h000, 1'b0);
    do_frame(2'd3, 1'b0, 8'h00, 1'b1, '0, 12'h3A1, 1'b0);
    do_frame(2'd3, 1'b1, 8'h00, 1'b1, '0, 12'h3A1, 1'b0);
    do_frame(2'd0, 1'b0, 8'hA5, 1'b1, 96'hFFFFFFFFFFFFFFFFFFFFFFFF, 12'h000, 1'b0); // R10
    do_frame(2'd2, 1'b0, 8'hFF, 1'b1, '0, 12'h000, 1'b0); // R10 all down
    do_frame(2'd0, 1'b0, 8'h00, 1'b1, 96'h0F0F0F0F0F0F0F0F0F0F0F0F, 12'h000, 1'b1); // R9
    do_frame(2'd3, 1'b1, 8'h11, 1'b1, '0, 12'hC5E, 1'b1); // R9
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m; logic msb; logic [7:0] pd; logic v; logic [95:0] d; logic [11:0] cu;
      m = 2'($urandom); msb = 1'($urandom); pd = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
      v = ($urandom % 5 != 0); d = {$urandom, $urandom, $urandom}; cu = 12'($urandom);
      do_frame(m, msb, pd, v, d, cu, 1'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule